// File: doc/BRIEF.md
# Threshold FIFO Transfer Requester

This block moves bytes between a disk-side byte stream and the host through a 16-byte FIFO, but only while a read or write command is in its execution phase. For a disk read the disk side fills the FIFO and the host drains it. For a disk write the host fills it and the disk side drains it. The block decides when to ask the host for service, based on the fill level and a programmable request threshold.

The host is told to act in one of two ways. In DMA mode a request line is driven, and each acknowledged cycle moves one byte. In programmed mode a ready-for-master status bit is driven together with an interrupt, and each host access strobe moves one byte. A bypass setting shrinks the FIFO to a single byte, so every byte gets its own handshake. The threshold field then has no effect.

Top module: `fifo_xfer_req`

## Requirements
- R1: After reset, `fill` is 0 and `dma_req`, `rqm`, `irq` and `xfer_err` are all 0.
- R2: With `cfg_pio`=0, a pending request appears only on `dma_req`. `rqm` and `irq` stay 0, and a byte moves on each cycle with `dma_ack`=1.
- R3: With `cfg_pio`=1, a pending request appears only on `rqm`, and `host_acc` moves the bytes. `irq` rises in the cycle the request becomes pending and falls after the next host access. `irq` is never 1 while `rqm` is 0.
- R4: The effective threshold is `cfg_thresh`+1, so a value of 0 means 1 byte and 15 means 16 bytes. On a disk read (`dir_read`=1), the request is raised once `fill` reaches the threshold.
- R5: On a disk read, a raised request stays asserted until `fill` is 0.
- R6: On a disk write (`dir_read`=0), the request is raised once the free space (capacity minus `fill`) reaches the threshold. It stays asserted until the FIFO is full.
- R7: With `cfg_fifo_off`=1, the capacity is 1 byte and the threshold is 1 byte, whatever `cfg_thresh` holds.
- R8: Each accepted push or pop changes `fill` by one, visible the cycle after the strobe. Bytes leave in the order they entered, and `head` shows the oldest byte. `fill` never exceeds the capacity.
- R9: When `exec_active` is 0, then in the following cycle `fill` is 0 and `dma_req`, `rqm`, `irq` and `xfer_err` are all 0.
- R10: A disk strobe is dropped and sets `xfer_err` in two cases. On a read, the FIFO is full and no host pop happens in the same cycle. On a write, the FIFO is empty. `xfer_err` then stays set until the phase ends.
- R11: A host transfer into a full FIFO on a write, or out of an empty FIFO on a read, is ignored and leaves `fill` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_off | input | 1 | 1 = bypass, single-byte handshakes |
| cfg_thresh | input | 4 | Threshold minus one |
| cfg_pio | input | 1 | 1 = status bit plus interrupt, 0 = DMA request |
| exec_active | input | 1 | Execution phase of a read/write command |
| dir_read | input | 1 | 1 = disk read (disk pushes), 0 = disk write (disk pops) |
| dsk_stb | input | 1 | Disk-side byte strobe (push on read, pop on write) |
| dsk_wdata | input | 8 | Byte from the disk side |
| host_acc | input | 1 | Host access strobe in programmed mode |
| dma_ack | input | 1 | DMA acknowledge, one byte per cycle |
| host_wdata | input | 8 | Byte from the host |
| head | output | 8 | Oldest byte in the FIFO |
| fill | output | 5 | Current fill level |
| dma_req | output | 1 | DMA request |
| rqm | output | 1 | Ready-for-master status bit |
| irq | output | 1 | Interrupt |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
Every result is held in a register. A strobe applied before a rising edge therefore shows up in `fill`, `head`, the request outputs, `irq` and `xfer_err` after exactly that one edge. Leaving the execution phase also clears everything one edge later. The bench drives inputs on the falling edge, lets a single rising edge pass, and compares the outputs on the next falling edge. Each expectation is thus checked in the first cycle it is due and never later. When a write phase opens, the request appears one edge after `exec_active` rises, and the bench checks it there.

// File: rtl/fifo_xfer_req.sv
module fifo_xfer_req #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_fifo_off,
  input  logic [$clog2(DEPTH)-1:0]      cfg_thresh,
  input  logic                          cfg_pio,
  input  logic                          exec_active,
  input  logic                          dir_read,
  input  logic                          dsk_stb,
  input  logic [DW-1:0]                 dsk_wdata,
  input  logic                          host_acc,
  input  logic                          dma_ack,
  input  logic [DW-1:0]                 host_wdata,
  output logic [DW-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]    fill,
  output logic                          dma_req,
  output logic                          rqm,
  output logic                          irq,
  output logic                          xfer_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl, lvl_n, cap, thr, free_n;
  logic          pend, pend_n, irq_q, irq_n, err_q;

  assign cap = cfg_fifo_off ? LW'(1) : LW'(DEPTH);
  assign thr = cfg_fifo_off ? LW'(1) : LW'(cfg_thresh) + LW'(1);

  wire hx    = exec_active & (cfg_pio ? host_acc : dma_ack);
  wire full  = lvl >= cap;
  wire empty = lvl == '0;
  wire pop   = exec_active & !empty & (dir_read ? hx : dsk_stb);
  wire push  = exec_active & (dir_read ? (dsk_stb & (!full | pop)) : (hx & !full));
  wire bad   = exec_active & dsk_stb & (dir_read ? (full & !pop) : empty);
  wire [DW-1:0] wdata = dir_read ? dsk_wdata : host_wdata;

  assign lvl_n  = lvl + LW'(push) - LW'(pop);
  assign free_n = cap - lvl_n;

  always_comb begin
    if (!exec_active)
      pend_n = 1'b0;
    else if (dir_read)
      pend_n = (lvl_n >= thr) | (pend & (lvl_n != '0));
    else
      pend_n = (free_n >= thr) | (pend & (lvl_n < cap));
  end

  assign irq_n = exec_active & cfg_pio & pend_n & (!pend | (irq_q & !hx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0;
      pend <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0;
    end else if (!exec_active) begin
      wp <= '0; rp <= '0; lvl <= '0;
      pend <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      lvl   <= lvl_n;
      pend  <= pend_n;
      irq_q <= irq_n;
      err_q <= err_q | bad;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign head     = mem[rp];
  assign fill     = lvl;
  assign dma_req  = pend & !cfg_pio;
  assign rqm      = pend & cfg_pio;
  assign irq      = irq_q;
  assign xfer_err = err_q;

  // R8
  lvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) fill <= cap);
  // R2
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dma_req && rqm));
  // R3
  irq_rqm_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> rqm);
  // R9
  exit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_active |=> (fill == '0) && !dma_req && !rqm && !irq && !xfer_err);
  // R5
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && dir_read && fill == '0) |-> !(dma_req || rqm));
  // R6
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && !dir_read && fill == cap) |-> !(dma_req || rqm));
  // R10
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && dir_read && dsk_stb && fill == cap && !(cfg_pio ? host_acc : dma_ack)) |=> xfer_err);
  // R10
  unr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_active && !dir_read && dsk_stb && fill == '0) |=> xfer_err);
endmodule

// File: tb/test_fifo_xfer_req.sv
module test_fifo_xfer_req;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fifo_off = 1'b1, cfg_pio = 1'b0, exec_active = 1'b0, dir_read = 1'b1;
  logic [3:0] cfg_thresh = 4'd0;
  logic dsk_stb = 1'b0, host_acc = 1'b0, dma_ack = 1'b0;
  logic [7:0] dsk_wdata = 8'd0, host_wdata = 8'd0;
  logic [7:0] head;
  logic [4:0] fill;
  logic dma_req, rqm, irq, xfer_err;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_xfer_req i_fifo_xfer_req (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(bit rd, bit pio, bit off, logic [3:0] th);
    dsk_stb = 0; host_acc = 0; dma_ack = 0;
    exec_active = 0; step();
    dir_read = rd; cfg_pio = pio; cfg_fifo_off = off; cfg_thresh = th;
    exec_active = 1; step();
  endtask

  task automatic dpush(logic [7:0] d);
    dsk_wdata = d; dsk_stb = 1; step(); dsk_stb = 0;
  endtask

  task automatic hstrobe(logic [7:0] d);
    host_wdata = d;
    if (cfg_pio) host_acc = 1; else dma_ack = 1;
    step(); host_acc = 0; dma_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1", "fill", fill, 0); chk("R1", "dma_req", dma_req, 0);
    chk("R1", "rqm", rqm, 0); chk("R1", "irq", irq, 0); chk("R1", "err", xfer_err, 0);
  endtask

  task automatic t_dma_read();
    start(1, 0, 0, 4'd2);
    dpush(8'hA0); chk("R4", "req@1", dma_req, 0);
    dpush(8'hA1); chk("R4", "req@2", dma_req, 0);
    dpush(8'hA2); chk("R4", "req@3", dma_req, 1);
    chk("R2", "rqm low", rqm, 0); chk("R2", "irq low", irq, 0);
    chk("R8", "head first", head, 8'hA0);
    hstrobe(8'h00);
    chk("R8", "fill after ack", fill, 2); chk("R5", "req held", dma_req, 1);
    chk("R8", "head second", head, 8'hA1);
    hstrobe(8'h00); chk("R5", "req held at 1", dma_req, 1);
    hstrobe(8'h00); chk("R5", "req drop at 0", dma_req, 0); chk("R8", "fill 0", fill, 0);
    // R11: ack with empty fifo ignored
    hstrobe(8'h00); chk("R11", "fill empty ack", fill, 0);
  endtask

  task automatic t_thr16();
    start(1, 0, 0, 4'hF);
    for (int i = 0; i < 15; i++) dpush(8'(i));
    chk("R4", "req@15", dma_req, 0);
    dpush(8'd15); chk("R4", "req@16", dma_req, 1); chk("R8", "fill 16", fill, 16);
    dpush(8'd99); chk("R10", "overrun err", xfer_err, 1); chk("R10", "fill kept", fill, 16);
    step(); chk("R10", "err sticky", xfer_err, 1);
    exec_active = 0; step();
    chk("R9", "fill clr", fill, 0); chk("R9", "req clr", dma_req, 0); chk("R9", "err clr", xfer_err, 0);
  endtask

  task automatic t_pio_write();
    start(0, 1, 0, 4'd3);
    chk("R6", "rqm at start", rqm, 1); chk("R3", "irq at start", irq, 1);
    chk("R3", "dma_req low", dma_req, 0);
    hstrobe(8'h10); chk("R3", "irq cleared", irq, 0); chk("R8", "fill 1", fill, 1);
    for (int i = 1; i < 16; i++) hstrobe(8'(8'h10 + i));
    chk("R6", "rqm full", rqm, 0); chk("R8", "fill 16", fill, 16);
    hstrobe(8'hEE); chk("R11", "full host write", fill, 16);
    chk("R8", "head order", head, 8'h10);
    dsk_stb = 1; step(); dsk_stb = 0;
    chk("R6", "free1 no req", rqm, 0); chk("R8", "head next", head, 8'h11);
    dsk_stb = 1; step(); step(); chk("R6", "free3 no req", rqm, 0);
    step(); dsk_stb = 0;
    chk("R6", "free4 req", rqm, 1); chk("R3", "irq again", irq, 1); chk("R8", "fill 12", fill, 12);
  endtask

  task automatic t_bypass();
    start(1, 0, 1, 4'd7);
    dpush(8'hB5); chk("R7", "req at 1", dma_req, 1); chk("R7", "head", head, 8'hB5);
    dpush(8'hB6); chk("R7", "cap 1 err", xfer_err, 1); chk("R7", "fill 1", fill, 1);
    start(0, 0, 1, 4'd7);
    chk("R7", "wr req start", dma_req, 1);
    hstrobe(8'hC1); chk("R7", "wr fill 1", fill, 1); chk("R7", "wr req off", dma_req, 0);
    dsk_stb = 1; step(); dsk_stb = 0;
    chk("R7", "wr fill 0", fill, 0); chk("R7", "wr req back", dma_req, 1);
    chk("R10", "no err yet", xfer_err, 0);
    dsk_stb = 1; step(); dsk_stb = 0;
    chk("R10", "underrun err", xfer_err, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_dma_read();
    t_thr16();
    t_pio_write();
    t_bypass();
    exec_active = 0; step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule